// File: doc/BRIEF.md
# DMA Abort and Recovery Sequencer

This block drives a descriptor DMA engine from an abort request back to a state from which it can be started again. When an abort is accepted it drops the engine enable. It then waits for the engine to acknowledge that it has stopped, and polls a status word until the engine reports that it is idle. After that it issues one cleanup cycle: the ring pointers and generation are reset, the length-check register is reloaded, and every pending request is flushed with an "aborted" code. Finally it starts the engine again, either at once or when the link comes up.

Neither wait can hang. A missing acknowledge is abandoned after a fixed number of tick periods. The idle poll has a bounded retry budget, and cleanup goes ahead once that budget is used up. A shutdown input overrides every state. It flushes pending work with a "shutdown" code and parks the block until reset.

States:
- OFFLINE: the reset state. Enable is low and the block waits for the link.
- RESTART: enable is held low for one cycle.
- IDLE: the engine is enabled.
- DISARMED: waiting for the disabled acknowledge.
- ABORTED: polling for quiescence.
- CLEANUP: the single cycle of cleanup pulses.
- SHUT_FLUSH: the single flush cycle of a shutdown.
- SHUT_HALT: terminal until reset.

Transitions:
- IDLE→DISARMED on an abort request.
- DISARMED→ABORTED on an acknowledge, or on the deadline tick.
- ABORTED→CLEANUP on a tick that finds the engine quiet or the retries exhausted.
- CLEANUP→RESTART when the link is active, otherwise CLEANUP→OFFLINE.
- OFFLINE→RESTART when the link is active.
- RESTART→IDLE.
- Any state→SHUT_FLUSH on shutdown, then SHUT_FLUSH→SHUT_HALT.

Top module: `dma_abort_seq`

## Requirements
- R1: After reset, `eng_enable_o`, `flush_o`, `ptr_reset_o` and `lencfg_load_o` are 0, and `lencfg_data_o` is 0. The block starts in OFFLINE.
- R2: An abort request is accepted only in IDLE. `eng_enable_o` is 0 from the cycle after acceptance. An abort request in any other state has no effect.
- R3: In DISARMED, an asserted `disabled_ack_i` moves the block to ABORTED at the next clock edge.
- R4: If no acknowledge arrives, the DEADLINE_TICKS-th tick spent in DISARMED moves the block to ABORTED. Cycles without a tick do not count toward the deadline.
- R5: The engine counts as quiet when `quiesce_status_i` bits 63, 62 and 61 are all 0 and bit 30 is 1. A tick in ABORTED with the engine quiet enters CLEANUP.
- R6: In ABORTED, each tick with the engine not quiet uses one retry. The tick after RETRY_LIMIT retries have been used enters CLEANUP regardless of status, so cleanup comes on non-quiet tick number RETRY_LIMIT+1.
- R7: CLEANUP lasts exactly one cycle. In that cycle `ptr_reset_o`, `lencfg_load_o` and `flush_o` are 1, `flush_code_o` is 0 (aborted), and `lencfg_data_o` = {1'b1 (check enable, MSB), RING_ENTRIES in the low LEN_W bits}. Outside that cycle `lencfg_data_o` is 0.
- R8: If `link_active_i` is 1 in the CLEANUP cycle, enable stays 0 for one more cycle (RESTART) and is 1 in the cycle after that (IDLE).
- R9: If the link is inactive at CLEANUP, enable stays 0 until `link_active_i` is seen high. It then rises two cycles later, after a one-cycle RESTART.
- R10: `shutdown_i` in any state gives one `flush_o` pulse with `flush_code_o` = 1 (shutdown) in the next cycle, with no `ptr_reset_o`. From then until reset, enable stays 0 and abort, link and tick inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_req_i | input | 1 | Request to abort the engine |
| disabled_ack_i | input | 1 | Engine reports that it has stopped |
| quiesce_status_i | input | 64 | Engine status word polled for quiescence |
| link_active_i | input | 1 | Link is up (level) |
| tick_i | input | 1 | Periodic timebase pulse |
| shutdown_i | input | 1 | Permanent stop request |
| eng_enable_o | output | 1 | Engine enable command |
| ptr_reset_o | output | 1 | Pulse: zero head, tail and generation |
| lencfg_load_o | output | 1 | Pulse: reload the length/generation-check register |
| lencfg_data_o | output | LEN_W+1 | Value for that register during the reload pulse |
| flush_o | output | 1 | Pulse: flush all pending requests |
| flush_code_o | output | 1 | Completion code for the flush: 0 aborted, 1 shutdown |

## Verification
An abort request and a shutdown can arrive in the same cycle while the block is in IDLE. The bench raises both inputs together on one clock edge. Shutdown must win: the next cycle carries a single flush with the shutdown code and no pointer reset. After that, the enable never returns, even with the link held up and more abort requests and ticks applied.

// File: rtl/dma_abort_pkg.sv
package dma_abort_pkg;

    typedef enum logic [2:0] {
        ST_OFFLINE,
        ST_RESTART,
        ST_IDLE,
        ST_DISARMED,
        ST_ABORTED,
        ST_CLEANUP,
        ST_SHUT_FLUSH,
        ST_SHUT_HALT
    } seq_state_e;

    typedef enum logic {
        FLUSH_ABORTED  = 1'b0,
        FLUSH_SHUTDOWN = 1'b1
    } flush_code_e;

    localparam int STAT_W        = 64;
    localparam int BUSY_BIT_A    = 63;
    localparam int BUSY_BIT_B    = 62;
    localparam int BUSY_BIT_C    = 61;
    localparam int STOPPED_BIT   = 30;

endpackage

// File: rtl/dma_tick_cnt.sv
module dma_tick_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (dec_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dma_quiet_chk.sv
module dma_quiet_chk
    import dma_abort_pkg::*;
(
    input  logic [STAT_W-1:0] status_i,
    output logic              quiet_o
);
    always_comb begin
        quiet_o = !status_i[BUSY_BIT_A] && !status_i[BUSY_BIT_B] &&
                  !status_i[BUSY_BIT_C] &&  status_i[STOPPED_BIT];
    end
endmodule

// File: rtl/dma_abort_seq.sv
module dma_abort_seq
    import dma_abort_pkg::*;
#(
    parameter int DEADLINE_TICKS = 6,
    parameter int RETRY_LIMIT    = 4,
    parameter int RING_ENTRIES   = 256,
    parameter int LEN_W          = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_req_i,
    input  logic              disabled_ack_i,
    input  logic [63:0]       quiesce_status_i,
    input  logic              link_active_i,
    input  logic              tick_i,
    input  logic              shutdown_i,
    output logic              eng_enable_o,
    output logic              ptr_reset_o,
    output logic              lencfg_load_o,
    output logic [LEN_W:0]    lencfg_data_o,
    output logic              flush_o,
    output logic              flush_code_o
);
    localparam int DL_W = (DEADLINE_TICKS > 1) ? $clog2(DEADLINE_TICKS) : 1;
    localparam int RT_W = $clog2(RETRY_LIMIT + 2);
    localparam logic [LEN_W:0] LENCFG_VAL = {1'b1, LEN_W'(RING_ENTRIES)};

    seq_state_e st_q, st_nx;
    logic       dl_zero, rt_zero, quiet, in_shut;

    dma_tick_cnt #(.W(DL_W)) u_deadline (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (st_q != ST_DISARMED),
        .load_val_i (DL_W'(DEADLINE_TICKS - 1)),
        .dec_i      (tick_i),
        .zero_o     (dl_zero)
    );

    dma_tick_cnt #(.W(RT_W)) u_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (st_q != ST_ABORTED),
        .load_val_i (RT_W'(RETRY_LIMIT)),
        .dec_i      (tick_i && !quiet),
        .zero_o     (rt_zero)
    );

    dma_quiet_chk u_quiet (
        .status_i (quiesce_status_i),
        .quiet_o  (quiet)
    );

    assign in_shut = (st_q == ST_SHUT_FLUSH) || (st_q == ST_SHUT_HALT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_OFFLINE;
        else
            st_q <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_OFFLINE:    if (link_active_i) st_nx = ST_RESTART;
            ST_RESTART:    st_nx = ST_IDLE;
            ST_IDLE:       if (abort_req_i) st_nx = ST_DISARMED;
            ST_DISARMED:   if (disabled_ack_i || (tick_i && dl_zero))
                               st_nx = ST_ABORTED;
            ST_ABORTED:    if (tick_i && (quiet || rt_zero))
                               st_nx = ST_CLEANUP;
            ST_CLEANUP:    st_nx = link_active_i ? ST_RESTART : ST_OFFLINE;
            ST_SHUT_FLUSH: st_nx = ST_SHUT_HALT;
            ST_SHUT_HALT:  st_nx = ST_SHUT_HALT;
        endcase
        if (shutdown_i && !in_shut)
            st_nx = ST_SHUT_FLUSH;
    end

    // output decode
    always_comb begin
        eng_enable_o  = 1'b0;
        ptr_reset_o   = 1'b0;
        lencfg_load_o = 1'b0;
        lencfg_data_o = '0;
        flush_o       = 1'b0;
        flush_code_o  = FLUSH_ABORTED;
        unique case (st_q)
            ST_IDLE:       eng_enable_o = 1'b1;
            ST_CLEANUP: begin
                ptr_reset_o   = 1'b1;
                lencfg_load_o = 1'b1;
                lencfg_data_o = LENCFG_VAL;
                flush_o       = 1'b1;
            end
            ST_SHUT_FLUSH: begin
                flush_o      = 1'b1;
                flush_code_o = FLUSH_SHUTDOWN;
            end
            ST_OFFLINE, ST_RESTART, ST_DISARMED, ST_ABORTED, ST_SHUT_HALT: ;
        endcase
    end
endmodule

// File: rtl/dma_abort_seq_chk.sv
module dma_abort_seq_chk #(
    parameter int RING_ENTRIES = 256,
    parameter int LEN_W        = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           abort_req_i,
    input logic           shutdown_i,
    input logic           eng_enable_o,
    input logic           ptr_reset_o,
    input logic           lencfg_load_o,
    input logic [LEN_W:0] lencfg_data_o,
    input logic           flush_o,
    input logic           flush_code_o
);
    localparam logic [LEN_W:0] EXP_CFG = {1'b1, LEN_W'(RING_ENTRIES)};

    AST_CLEANUP_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_reset_o |-> (flush_o && lencfg_load_o && !flush_code_o)); // R7
    AST_CFG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        lencfg_load_o |-> (lencfg_data_o == EXP_CFG)); // R7
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o); // R7
    AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_enable_o) |-> !$past(ptr_reset_o)); // R8
    AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_enable_o && abort_req_i) |=> !eng_enable_o); // R2
    AST_SHUT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_i |=> (!eng_enable_o && !ptr_reset_o)); // R10
    AST_NO_FLUSH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_enable_o |-> !flush_o); // R10
endmodule

bind dma_abort_seq dma_abort_seq_chk #(
    .RING_ENTRIES (RING_ENTRIES),
    .LEN_W        (LEN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort_req_i   (abort_req_i),
    .shutdown_i    (shutdown_i),
    .eng_enable_o  (eng_enable_o),
    .ptr_reset_o   (ptr_reset_o),
    .lencfg_load_o (lencfg_load_o),
    .lencfg_data_o (lencfg_data_o),
    .flush_o       (flush_o),
    .flush_code_o  (flush_code_o)
);

// File: tb/dma_abort_seq_test.sv
`timescale 1ns/1ps
module dma_abort_seq_test;
    localparam int D    = 6;
    localparam int RL   = 4;
    localparam int RING = 256;
    localparam int LW   = 16;
    localparam logic [LW:0] EXP_CFG = {1'b1, LW'(RING)};
    localparam logic [63:0] QUIET   = 64'h0000_0000_4000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic abort_req_i = 1'b0, disabled_ack_i = 1'b0, link_active_i = 1'b0;
    logic tick_i = 1'b0, shutdown_i = 1'b0;
    logic [63:0] quiesce_status_i = '0;
    logic eng_enable_o, ptr_reset_o, lencfg_load_o, flush_o, flush_code_o;
    logic [LW:0] lencfg_data_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dma_abort_seq #(.DEADLINE_TICKS(D), .RETRY_LIMIT(RL),
                    .RING_ENTRIES(RING), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .abort_req_i(abort_req_i),
        .disabled_ack_i(disabled_ack_i), .quiesce_status_i(quiesce_status_i),
        .link_active_i(link_active_i), .tick_i(tick_i), .shutdown_i(shutdown_i),
        .eng_enable_o(eng_enable_o), .ptr_reset_o(ptr_reset_o),
        .lencfg_load_o(lencfg_load_o), .lencfg_data_o(lencfg_data_o),
        .flush_o(flush_o), .flush_code_o(flush_code_o));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic tk);
        @(negedge clk);
        tick_i = tk;
        @(posedge clk);
        #1;
        tick_i = 1'b0;
    endtask

    task automatic do_abort();
        abort_req_i = 1'b1;
        cyc(1'b0);
        abort_req_i = 1'b0;
    endtask

    task automatic do_ack();
        disabled_ack_i = 1'b1;
        cyc(1'b0);
        disabled_ack_i = 1'b0;
    endtask

    // ticks (with an idle cycle between) until a flush is seen
    task automatic ticks_to_flush(output int n);
        n = 0;
        while (n < 30) begin
            cyc(1'b1);
            n++;
            if (flush_o) break;
            cyc(1'b0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        abort_req_i = 0; disabled_ack_i = 0; shutdown_i = 0; link_active_i = 0;
        repeat (3) cyc(1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 enable", eng_enable_o, 0);
        chk("R1 flush", flush_o, 0);
        chk("R1 ptr_reset", ptr_reset_o, 0);
        chk("R1 cfg", {lencfg_load_o, lencfg_data_o}, 0);
        repeat (3) cyc(1'b0);
        chk("R1 offline w/o link", eng_enable_o, 0);
        link_active_i = 1'b1;
        cyc(1'b0);
        chk("R1 restart gap", eng_enable_o, 0);
        cyc(1'b0);
        chk("R1 enabled", eng_enable_o, 1);
    endtask

    task automatic t_ack_path();
        quiesce_status_i = 64'h8000_0000_4000_0000;
        do_abort();
        chk("R2 enable drops", eng_enable_o, 0);
        do_ack();
        quiesce_status_i = QUIET;
        cyc(1'b1);
        chk("R3 R5 flush after ack+quiet tick", flush_o, 1);
        chk("R7 ptr_reset", ptr_reset_o, 1);
        chk("R7 cfg load", lencfg_load_o, 1);
        chk("R7 cfg data", lencfg_data_o, EXP_CFG);
        chk("R7 code aborted", flush_code_o, 0);
        cyc(1'b0);
        chk("R7 one cycle", {flush_o, ptr_reset_o, lencfg_load_o}, 0);
        chk("R7 cfg cleared", lencfg_data_o, 0);
        chk("R8 restart low", eng_enable_o, 0);
        cyc(1'b0);
        chk("R8 enabled", eng_enable_o, 1);
    endtask

    task automatic t_deadline();
        int n;
        quiesce_status_i = QUIET;
        do_abort();
        ticks_to_flush(n);
        chk("R4 ticks to cleanup", n, D + 1);
        cyc(1'b0); cyc(1'b0);
        chk("R4 back to idle", eng_enable_o, 1);
    endtask

    task automatic t_retry(input logic [63:0] busy, input string tag);
        int n;
        do_abort();
        quiesce_status_i = busy;
        do_ack();
        ticks_to_flush(n);
        chk({"R6 retries ", tag}, n, RL + 1);
        cyc(1'b0); cyc(1'b0);
        chk("R6 back to idle", eng_enable_o, 1);
    endtask

    task automatic t_early_quiet();
        do_abort();
        quiesce_status_i = 64'h2000_0000_4000_0000;
        do_ack();
        cyc(1'b1);
        chk("R5 bit61 busy", flush_o, 0);
        cyc(1'b1);
        chk("R5 still busy", flush_o, 0);
        quiesce_status_i = QUIET;
        cyc(1'b1);
        chk("R5 quiet tick cleans", flush_o, 1);
        cyc(1'b0); cyc(1'b0);
    endtask

    task automatic t_link_down();
        do_abort();
        do_ack();
        quiesce_status_i = QUIET;
        link_active_i = 1'b0;
        cyc(1'b1);
        chk("R9 cleanup", flush_o, 1);
        repeat (3) cyc(1'b0);
        chk("R9 stays off", eng_enable_o, 0);
        do_abort();
        chk("R2 abort ignored offline", flush_o, 0);
        cyc(1'b0);
        chk("R9 still off", eng_enable_o, 0);
        link_active_i = 1'b1;
        cyc(1'b0);
        chk("R9 restart gap", eng_enable_o, 0);
        cyc(1'b0);
        chk("R2 R9 enabled, abort not taken", eng_enable_o, 1);
    endtask

    task automatic t_shutdown_race();
        logic seen;
        abort_req_i = 1'b1;
        shutdown_i = 1'b1;
        cyc(1'b0);
        abort_req_i = 1'b0;
        shutdown_i = 1'b0;
        chk("R10 flush", flush_o, 1);
        chk("R10 code shutdown", flush_code_o, 1);
        chk("R10 no ptr reset", ptr_reset_o, 0);
        chk("R10 enable off", eng_enable_o, 0);
        seen = 1'b0;
        quiesce_status_i = QUIET;
        for (int i = 0; i < 10; i++) begin
            abort_req_i = (i == 3);
            disabled_ack_i = (i == 5);
            cyc(1'b1);
            if (flush_o || eng_enable_o || ptr_reset_o) seen = 1'b1;
        end
        abort_req_i = 1'b0;
        disabled_ack_i = 1'b0;
        chk("R10 parked", seen, 0);
    endtask

    task automatic t_shutdown_aborted();
        logic seen;
        do_abort();
        quiesce_status_i = 64'h4000_0000_4000_0000;
        do_ack();
        cyc(1'b1);
        shutdown_i = 1'b1;
        cyc(1'b0);
        chk("R10 flush from aborted", {flush_o, flush_code_o, ptr_reset_o}, 3'b110);
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            cyc(1'b1);
            if (flush_o || eng_enable_o) seen = 1'b1;
        end
        shutdown_i = 1'b0;
        chk("R10 held low", seen, 0);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ack_path();
        t_deadline();
        t_retry(64'h8000_0000_4000_0000, "bit63");
        t_retry(64'h4000_0000_4000_0000, "bit62");
        t_retry(64'h2000_0000_4000_0000, "bit61");
        t_retry(64'h0000_0000_0000_0000, "bit30 clear");
        t_early_quiet();
        t_link_down();
        t_shutdown_race();
        t_reset();
        t_shutdown_aborted();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule